// File: doc/BRIEF.md
# Display Pipeline Frame-Boundary Lock Controller

This block holds ten hardware locks that software uses to change the shadowed settings of display pipeline stages safely. Each lock has a membership mask over 64 pipeline stages and a choice of start-of-frame trigger. Software enables a lock and raises its request. Once no frame is in flight, the block reports the grant through a status bit. Software then rewrites the settings of the member stages. It releases the lock by clearing the request. From that point the block schedules one "apply shadow settings" strobe on `apply_mod` for every member stage. The strobe fires at the next start-of-frame pulse of the chosen source, or straight away when the lock runs in software-triggered mode.

Access is a plain single-cycle 32-bit register port with no back-pressure. A write takes effect at the clock edge where `bus_en` and `bus_we` are high. A read returns data combinationally in the same cycle and has no side effect. Each lock occupies a 32-byte window, and the first window starts at byte 0x20. Trigger and idle inputs are level or pulse signals, one per source. There is no stream interface.

Top module: `disp_sync_mutex`

## Requirements
- R1: After reset, every register reads 0 and `apply_mod` is 0.
- R2: Lock n (0..9) decodes from base B = 0x20 + 0x20·n. B+0x00 is enable (bit 0). B+0x04 is request/status: bit 0 is the request and is writable, bit 1 is the grant and is read-only. B+0x08 is the lock reset (bit 0). B+0x0C is the mask for stages 0..31 (bit i = stage i). B+0x10 is the trigger select (bits 2:0). B+0x14 is the mask for stages 32..63 (bit i = stage 32+i). Every writable field reads back what was written, and a write changes no other lock.
- R3: A read of any other address, including an unaligned one, returns 0. A write to such an address changes no register.
- R4: With trigger select 0 (software mode), the grant bit reads 1 in the cycle after the edge at which both enable and request are first 1. With enable at 0, the request bit holds but the grant is never given.
- R5: With trigger select s in 1..6, the grant waits until `src_idle[s-1]` is 1. After the grant is given it holds while the request stays set.
- R6: Writing 0 to the request of a granted lock clears both the request and the grant at that write's edge. In software mode, `apply_mod` then carries {mask 32..63, mask 0..31} for exactly one cycle, starting one cycle after the write's edge.
- R7: In source mode s, after release, `apply_mod` carries the mask for one cycle, in the cycle after the clock edge that samples `sof_pulse[s-1]` high. Pulses from other sources, and any pulse while the lock is granted, produce no strobe.
- R8: While the lock reset bit is 1, request, grant and any pending strobe are held cleared, and request writes are ignored. Enable, masks and trigger select are kept.
- R9: Trigger select 7 behaves as software mode.
- R10: Writing 0 to enable of a granted lock removes the grant at that edge. The request bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle, 0 when not reading a mapped register |
| sof_pulse | input | 6 | Start-of-frame pulse per source (bit k = select code k+1) |
| src_idle | input | 6 | Source between frames, safe to grant (bit k = select code k+1) |
| apply_mod | output | 64 | One-cycle strobe per pipeline stage to apply shadow settings |

## Verification
The bench targets the grant timing in both trigger styles. A design that grants a frame-triggered lock without checking the selected idle input would show grant=1 while the source is busy. A strobe that fires at release in frame mode would appear before the trigger pulse, and one that fires on the wrong source's pulse would appear on an unrelated frame. Membership is set on both sides of stage 32, so a mask split placed one bit off would put the strobe on the wrong stage. A lock reset while granted must leave no pending strobe behind, because a stray strobe later would commit settings midway through a software update.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic [2:0] {
    K_EN   = 3'd0,
    K_REQ  = 3'd1,
    K_RST  = 3'd2,
    K_MLO  = 3'd3,
    K_SEL  = 3'd4,
    K_MHI  = 3'd5,
    K_NONE = 3'd7
  } reg_kind_e;

  localparam int MASK_SPLIT = 32;
endpackage

// File: rtl/dmx_decode.sv
module dmx_decode
  import dmx_pkg::*;
#(
  parameter int N_MUT  = 10,
  parameter int AW     = 9,
  parameter int BASE   = 32,
  parameter int STRIDE = 32,
  parameter int IW     = $clog2(N_MUT)
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output reg_kind_e     kind
);
  localparam int SH = $clog2(STRIDE);

  logic [AW-1:0] off;
  logic [SH-1:0] loc;

  always_comb begin
    off  = addr - AW'(BASE);
    loc  = off[SH-1:0];
    kind = K_NONE;
    idx  = '0;
    if (addr >= AW'(BASE) && (off >> SH) < AW'(N_MUT)) begin
      idx = IW'(off >> SH);
      case (loc)
        SH'(0):  kind = K_EN;
        SH'(4):  kind = K_REQ;
        SH'(8):  kind = K_RST;
        SH'(12): kind = K_MLO;
        SH'(16): kind = K_SEL;
        SH'(20): kind = K_MHI;
        default: kind = K_NONE;
      endcase
    end
    hit = (kind != K_NONE);
  end
endmodule

// File: rtl/dmx_slot.sv
module dmx_slot
  import dmx_pkg::*;
#(
  parameter int N_SRC = 6,
  parameter int NMOD  = 64,
  parameter int SELW  = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  reg_kind_e        kind,
  input  logic [31:0]      wd,
  input  logic [N_SRC-1:0] sof,
  input  logic [N_SRC-1:0] idle,
  output logic [31:0]      rd_val,
  output logic             grant_o,
  output logic             en_o,
  output logic             req_o,
  output logic             rst_o,
  output logic             pend_o,
  output logic [NMOD-1:0]  apply_o
);
  localparam int HW = NMOD - MASK_SPLIT;

  logic            en_q, req_q, g_q, rs_q, p_q;
  logic [SELW-1:0] sel_q;
  logic [31:0]     lo_q;
  logic [HW-1:0]   hi_q;
  logic [NMOD-1:0] ap_q;

  logic en_n, req_n, rs_n, g_n, p_n;
  logic single, ready, fire, release_ev, commit;

  always_comb begin
    en_n = (wr && kind == K_EN)  ? wd[0] : en_q;
    rs_n = (wr && kind == K_RST) ? wd[0] : rs_q;
    req_n = (wr && kind == K_REQ) ? wd[0] : req_q;
    if (rs_n) req_n = 1'b0;

    single = (sel_q == '0) || (sel_q > SELW'(N_SRC));
    ready  = single;
    fire   = single;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_q == SELW'(i + 1)) begin
        ready = idle[i];
        fire  = sof[i];
      end
    end

    g_n = !rs_n && en_n && req_n && (g_q || (req_q && en_q && ready));
    release_ev = g_q && !req_n && !rs_n && en_n;
    commit = p_q && en_q && !g_q && fire;
    p_n = !rs_n && (release_ev || (p_q && !commit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      req_q <= 1'b0;
      g_q   <= 1'b0;
      rs_q  <= 1'b0;
      p_q   <= 1'b0;
      sel_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      ap_q  <= '0;
    end else begin
      en_q  <= en_n;
      req_q <= req_n;
      g_q   <= g_n;
      rs_q  <= rs_n;
      p_q   <= p_n;
      if (wr && kind == K_MLO) lo_q  <= wd;
      if (wr && kind == K_SEL) sel_q <= wd[SELW-1:0];
      if (wr && kind == K_MHI) hi_q  <= wd[HW-1:0];
      ap_q <= commit ? {hi_q, lo_q} : '0;
    end
  end

  always_comb begin
    case (kind)
      K_EN:    rd_val = {31'b0, en_q};
      K_REQ:   rd_val = {30'b0, g_q, req_q};
      K_RST:   rd_val = {31'b0, rs_q};
      K_MLO:   rd_val = lo_q;
      K_SEL:   rd_val = 32'(sel_q);
      K_MHI:   rd_val = 32'(hi_q);
      default: rd_val = '0;
    endcase
  end

  assign grant_o = g_q;
  assign en_o    = en_q;
  assign req_o   = req_q;
  assign rst_o   = rs_q;
  assign pend_o  = p_q;
  assign apply_o = ap_q;
endmodule

// File: rtl/disp_sync_mutex.sv
module disp_sync_mutex
  import dmx_pkg::*;
#(
  parameter int N_MUT = 10,
  parameter int N_SRC = 6,
  parameter int NMOD  = 64,
  parameter int AW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [N_SRC-1:0] sof_pulse,
  input  logic [N_SRC-1:0] src_idle,
  output logic [NMOD-1:0]  apply_mod
);
  localparam int IW = $clog2(N_MUT);

  logic          dec_hit;
  logic [IW-1:0] dec_idx;
  reg_kind_e     dec_kind;

  logic [31:0]     slot_rd [N_MUT];
  logic [NMOD-1:0] slot_ap [N_MUT];
  logic [N_MUT-1:0] grant_vec, en_vec, req_vec, rst_vec, pend_vec, apply_any;

  dmx_decode #(.N_MUT(N_MUT), .AW(AW), .IW(IW)) u_dec (
    .addr (bus_addr),
    .hit  (dec_hit),
    .idx  (dec_idx),
    .kind (dec_kind)
  );

  for (genvar n = 0; n < N_MUT; n++) begin : g_slot
    logic slot_wr;
    assign slot_wr = bus_en && bus_we && dec_hit && (dec_idx == IW'(n));

    dmx_slot #(.N_SRC(N_SRC), .NMOD(NMOD)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (slot_wr),
      .kind    (dec_kind),
      .wd      (bus_wdata),
      .sof     (sof_pulse),
      .idle    (src_idle),
      .rd_val  (slot_rd[n]),
      .grant_o (grant_vec[n]),
      .en_o    (en_vec[n]),
      .req_o   (req_vec[n]),
      .rst_o   (rst_vec[n]),
      .pend_o  (pend_vec[n]),
      .apply_o (slot_ap[n])
    );

    assign apply_any[n] = |slot_ap[n];
  end

  always_comb begin
    apply_mod = '0;
    for (int n = 0; n < N_MUT; n++) apply_mod = apply_mod | slot_ap[n];
  end

  assign bus_rdata = (bus_en && !bus_we && dec_hit) ? slot_rd[dec_idx] : 32'd0;
endmodule

// File: rtl/dmx_check.sv
module dmx_check #(
  parameter int N_MUT = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             bus_we,
  input logic             hit,
  input logic [31:0]      bus_rdata,
  input logic [N_MUT-1:0] grant_vec,
  input logic [N_MUT-1:0] en_vec,
  input logic [N_MUT-1:0] req_vec,
  input logic [N_MUT-1:0] rst_vec,
  input logic [N_MUT-1:0] pend_vec,
  input logic [N_MUT-1:0] apply_any
);
  a_r3_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !hit) |-> (bus_rdata == 32'd0));

  for (genvar n = 0; n < N_MUT; n++) begin : g_chk
    a_r4_grant_needs_en_req: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vec[n] |-> (en_vec[n] && req_vec[n]));

    a_r8_reset_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
      rst_vec[n] |=> (!grant_vec[n] && !pend_vec[n]));

    a_r7_no_apply_while_granted: assert property (@(posedge clk) disable iff (!rst_n)
      apply_any[n] |-> (!$past(grant_vec[n]) && $past(pend_vec[n])));

    a_r6_apply_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      apply_any[n] |=> !apply_any[n]);
  end
endmodule

bind disp_sync_mutex dmx_check #(.N_MUT(N_MUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .hit       (dec_hit),
  .bus_rdata (bus_rdata),
  .grant_vec (grant_vec),
  .en_vec    (en_vec),
  .req_vec   (req_vec),
  .rst_vec   (rst_vec),
  .pend_vec  (pend_vec),
  .apply_any (apply_any)
);

// File: tb/sim_disp_sync_mutex.sv
`timescale 1ns/1ps
module sim_disp_sync_mutex;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  sof_pulse = '0, src_idle = '0;
  logic [63:0] apply_mod;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disp_sync_mutex u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sof_pulse(sof_pulse), .src_idle(src_idle), .apply_mod(apply_mod)
  );

  // ---------------- behavioural reference ----------------
  bit          m_en[10], m_req[10], m_g[10], m_rs[10], m_p[10];
  logic [2:0]  m_sel[10];
  logic [31:0] m_lo[10], m_hi[10];
  logic [63:0] m_apply;

  function automatic bit mdec(input logic [8:0] a, output int n, output int k);
    n = 0; k = 0;
    if (a < 9'd32) return 1'b0;
    n = (int'(a) - 32) / 32;
    k = (int'(a) - 32) % 32;
    return (n < 10) && (k == 0 || k == 4 || k == 8 || k == 12 || k == 16 || k == 20);
  endfunction

  function automatic logic [31:0] mread(input int n, input int k);
    case (k)
      0:  return {31'b0, m_en[n]};
      4:  return {30'b0, m_g[n], m_req[n]};
      8:  return {31'b0, m_rs[n]};
      12: return m_lo[n];
      16: return {29'b0, m_sel[n]};
      default: return m_hi[n];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int wn, wk;
    bit wh, mine, ne, nr, ns, sw, rdy, fire, ng, cm, np;
    logic [63:0] acc;
    if (!rst_n) begin
      for (int n = 0; n < 10; n++) begin
        m_en[n] = 0; m_req[n] = 0; m_g[n] = 0; m_rs[n] = 0; m_p[n] = 0;
        m_sel[n] = 0; m_lo[n] = 0; m_hi[n] = 0;
      end
      m_apply = '0;
    end else begin
      wh = mdec(bus_addr, wn, wk) && bus_en && bus_we;
      acc = '0;
      for (int n = 0; n < 10; n++) begin
        mine = wh && (wn == n);
        ne = m_en[n]; nr = m_req[n]; ns = m_rs[n];
        if (mine && wk == 0) ne = bus_wdata[0];
        if (mine && wk == 4) nr = bus_wdata[0];
        if (mine && wk == 8) ns = bus_wdata[0];
        if (ns) nr = 0;
        sw   = (m_sel[n] == 0) || (m_sel[n] == 7);
        rdy  = sw ? 1'b1 : src_idle[m_sel[n] - 3'd1];
        fire = sw ? 1'b1 : sof_pulse[m_sel[n] - 3'd1];
        ng = 0;
        if (!ns && ne && nr) ng = m_g[n] || (m_req[n] && m_en[n] && rdy);
        cm = m_p[n] && m_en[n] && !m_g[n] && fire;
        np = 0;
        if (!ns) np = (m_g[n] && !nr && ne) || (m_p[n] && !cm);
        if (cm) acc = acc | {m_hi[n], m_lo[n]};
        if (mine && wk == 12) m_lo[n] = bus_wdata;
        if (mine && wk == 16) m_sel[n] = bus_wdata[2:0];
        if (mine && wk == 20) m_hi[n] = bus_wdata;
        m_en[n] = ne; m_req[n] = nr; m_rs[n] = ns; m_g[n] = ng; m_p[n] = np;
      end
      m_apply = acc;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    int n, k;
    logic [31:0] er;
    #2;
    if (rst_n) begin
      er = 32'd0;
      if (bus_en && !bus_we && mdec(bus_addr, n, k)) er = mread(n, k);
      chk("R2 model rdata", {32'b0, bus_rdata}, {32'b0, er});
      chk("R7 model apply_mod", apply_mod, m_apply);
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [8:0] ra(input int n, input int off);
    return 9'(32 + 32 * n + off);
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    rd(ra(0, 4), d);   chk("R1 status after reset", {32'b0, d}, 64'd0);
    rd(ra(9, 12), d);  chk("R1 mask after reset", {32'b0, d}, 64'd0);
    chk("R1 apply after reset", apply_mod, 64'd0);

    // R2: map and readback, window isolation
    wr(ra(2, 12), 32'hA5A5_0001);
    wr(ra(2, 20), 32'h0000_00F3);
    wr(ra(2, 16), 32'd4);
    rd(ra(2, 12), d);  chk("R2 mask low readback", {32'b0, d}, 64'hA5A5_0001);
    rd(ra(2, 20), d);  chk("R2 mask high readback", {32'b0, d}, 64'h0000_00F3);
    rd(ra(2, 16), d);  chk("R2 select readback", {32'b0, d}, 64'd4);
    rd(ra(1, 12), d);  chk("R2 neighbour untouched", {32'b0, d}, 64'd0);

    // R3: unmapped
    wr(9'h038, 32'hFFFF_FFFF);
    wr(9'h022, 32'hFFFF_FFFF);
    rd(9'h038, d);     chk("R3 gap read", {32'b0, d}, 64'd0);
    rd(9'h000, d);     chk("R3 below base read", {32'b0, d}, 64'd0);
    rd(9'h160, d);     chk("R3 above top read", {32'b0, d}, 64'd0);
    rd(9'h022, d);     chk("R3 unaligned read", {32'b0, d}, 64'd0);
    rd(ra(0, 12), d);  chk("R3 no side write low", {32'b0, d}, 64'd0);
    rd(ra(0, 0), d);   chk("R3 no side write enable", {32'b0, d}, 64'd0);

    // R4 / R6: software mode, masks on both sides of stage 32
    wr(ra(0, 4), 32'd1);
    repeat (2) @(negedge clk);
    rd(ra(0, 4), d);   chk("R4 no grant while disabled", {32'b0, d}, 64'd1);
    wr(ra(0, 0), 32'd1);
    rd(ra(0, 4), d);   chk("R4 grant in software mode", {32'b0, d}, 64'd3);
    wr(ra(0, 12), 32'h8000_0001);
    wr(ra(0, 20), 32'h0000_0001);
    wr(ra(0, 4), 32'd0);
    chk("R6 no strobe at release edge", apply_mod, 64'd0);
    @(negedge clk);
    chk("R6 strobe one cycle later", apply_mod, 64'h0000_0001_8000_0001);
    @(negedge clk);
    chk("R6 strobe lasts one cycle", apply_mod, 64'd0);
    rd(ra(0, 4), d);   chk("R6 status cleared", {32'b0, d}, 64'd0);

    // R5 / R7: frame mode on source code 1
    wr(ra(3, 16), 32'd1);
    wr(ra(3, 12), 32'h0000_0020);
    wr(ra(3, 20), 32'h0000_0004);
    wr(ra(3, 0), 32'd1);
    wr(ra(3, 4), 32'd1);
    repeat (4) @(negedge clk);
    rd(ra(3, 4), d);   chk("R5 grant withheld mid-frame", {32'b0, d}, 64'd1);
    src_idle = 6'b000001;
    rd(ra(3, 4), d);   chk("R5 grant in idle window", {32'b0, d}, 64'd3);
    src_idle = 6'b000000;
    rd(ra(3, 4), d);   chk("R5 grant held", {32'b0, d}, 64'd3);
    @(negedge clk); sof_pulse = 6'b000001;
    @(negedge clk); sof_pulse = 6'b000000;
    chk("R7 no strobe while granted", apply_mod, 64'd0);
    wr(ra(3, 4), 32'd0);
    repeat (3) @(negedge clk);
    chk("R7 waits for frame start", apply_mod, 64'd0);
    sof_pulse = 6'b000010;
    @(negedge clk); sof_pulse = 6'b000000;
    chk("R7 other source ignored", apply_mod, 64'd0);
    sof_pulse = 6'b000001;
    @(negedge clk); sof_pulse = 6'b000000;
    chk("R7 strobe on selected frame start", apply_mod, 64'h0000_0004_0000_0020);
    @(negedge clk);
    chk("R7 strobe lasts one cycle", apply_mod, 64'd0);

    // R8: lock reset while granted
    wr(ra(5, 12), 32'h0000_00F0);
    wr(ra(5, 0), 32'd1);
    wr(ra(5, 4), 32'd1);
    rd(ra(5, 4), d);   chk("R8 granted before reset", {32'b0, d}, 64'd3);
    wr(ra(5, 8), 32'd1);
    rd(ra(5, 4), d);   chk("R8 reset clears grant", {32'b0, d}, 64'd0);
    wr(ra(5, 4), 32'd1);
    rd(ra(5, 4), d);   chk("R8 request ignored in reset", {32'b0, d}, 64'd0);
    wr(ra(5, 8), 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 no pending strobe", apply_mod, 64'd0);
    rd(ra(5, 0), d);   chk("R8 enable kept", {32'b0, d}, 64'd1);
    rd(ra(5, 12), d);  chk("R8 mask kept", {32'b0, d}, 64'h0000_00F0);
    wr(ra(5, 4), 32'd1);
    rd(ra(5, 4), d);   chk("R8 grant after reset ends", {32'b0, d}, 64'd3);

    // R9: select 7 acts as software mode
    wr(ra(9, 16), 32'd7);
    wr(ra(9, 0), 32'd1);
    wr(ra(9, 4), 32'd1);
    rd(ra(9, 4), d);   chk("R9 select 7 grants at once", {32'b0, d}, 64'd3);

    // R10: disable drops grant, keeps request
    wr(ra(9, 0), 32'd0);
    rd(ra(9, 4), d);   chk("R10 disable removes grant", {32'b0, d}, 64'd1);

    repeat (3) @(negedge clk);
    done = 1;
    report();
    $finish;
  end
endmodule